// File: doc/BRIEF.md
# Bit-Serial Lowest-Priority Arbitration Node

This block is one contender in the arbitration phase of a serial interrupt message. Several nodes share an open-drain line. A node asserts a logic one by pulling the line low, so the line behaves as a wired-AND of the levels the nodes drive. A single pulse on `phase_start` opens the phase. The node then latches its 8-bit processor priority, its 4-bit arbitration ID and its free-slot flag. It drives twelve one-cycle bit slots onto the line and samples the combined line value in every slot.

The first eight slots carry the inverted priority, most significant bit first. The wire level in priority slot k is therefore the priority bit itself, and the node with the lowest priority wins. The last four slots carry the arbitration ID without inversion, also most significant bit first. The wire level there is the inverted ID bit, so when priorities are equal the highest ID wins.

A node that releases the line (level 1) but samples it low has lost. It keeps the line released for every remaining slot. A node without a free slot keeps the line released for the whole phase. After the twelfth slot, `won` rises if the node took part and never lost. It stays high until the next phase start.

The sequencer has four states:
- `ST_IDLE`: after reset.
- `ST_PRIO`: priority slots 0 to 7.
- `ST_TIE`: ID slots 8 to 11.
- `ST_DONE`: result held.

Its transitions are:
- start: any state to `ST_PRIO` on `phase_start`.
- prio_end: `ST_PRIO` to `ST_TIE` after slot 7.
- tie_end: `ST_TIE` to `ST_DONE` after slot 11.

Top module: `lp_arb_node`

## Requirements
- R1: After reset, `line1_level` is 1 and `won` is 0 until the first `phase_start`.
- R2: In the first cycle after `phase_start`, the node is in slot 0. In priority slot k (k = 0..7), a taking-part node that has not lost drives `line1_level` equal to priority bit 7-k. This is the inverted priority bit, written active-low on the wire.
- R3: In slot 8+j (j = 0..3), a taking-part node that has not lost drives `line1_level` equal to the inverse of ID bit 3-j.
- R4: A node whose `slot_free` was 0 at phase start drives `line1_level` = 1 in all twelve slots, and its `won` stays 0.
- R5: When the node drives 1 in a slot and samples `line1_sense` = 0 in that slot, it drives 1 in every later slot of the phase.
- R6: `won` is 0 during the twelve slots. In the cycle after slot 11 it equals (took part and never lost), and it holds that value until the next `phase_start`.
- R7: A `phase_start` in the middle of a phase clears the lost state and restarts at slot 0 with freshly latched inputs.
- R8: Against a rival, the node wins when its priority is numerically lower. At equal priority it wins when its ID is higher or equal (with equal IDs both nodes report a win).
- R9: Changes of `prio_in`, `arb_id_in` or `slot_free` after `phase_start` have no effect on the slot levels or on `won` for that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_start | input | 1 | One-cycle pulse opening the arbitration phase |
| prio_in | input | 8 | Processor priority, latched at phase start |
| arb_id_in | input | 4 | Arbitration ID, latched at phase start |
| slot_free | input | 1 | Node has a free interrupt slot and takes part |
| line1_sense | input | 1 | Sampled wired-AND value of the shared line |
| line1_level | output | 1 | Level this node drives (1 = released) |
| won | output | 1 | Node won the phase |

## Verification
The hardest situation to reach is a loss in the middle of the phase, followed by the released line in all later slots. It needs a second contender whose pulled-low bits depend on its own loss history. The bench models a rival node cycle by cycle and ANDs the rival's level with the node's actual level to form `line1_sense`. It chooses priority and ID pairs so that the decision falls in an early priority slot, in the last priority slot, in the ID slots, or never. A restart in the middle of a phase after a forced loss is reached by holding the sensed line low for a few slots before a second start pulse.

// File: rtl/lp_arb_pkg.sv
package lp_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRIO = 2'd1,
        ST_TIE  = 2'd2,
        ST_DONE = 2'd3
    } arb_state_e;

endpackage

// File: rtl/lp_arb_bitsel.sv
module lp_arb_bitsel
    import lp_arb_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 4,
    parameter int CNT_W  = 4
) (
    input  arb_state_e        state_i,
    input  logic [CNT_W-1:0]  slot_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [ID_W-1:0]   id_i,
    output logic              bit_level_o
);

    // Wire level that the current slot asks for; gating by loss is done above.
    always_comb begin
        bit_level_o = 1'b1;
        unique case (state_i)
            ST_PRIO: begin
                for (int i = 0; i < PRIO_W; i++) begin
                    if (slot_i == CNT_W'(i)) bit_level_o = prio_i[PRIO_W-1-i];
                end
            end
            ST_TIE: begin
                for (int j = 0; j < ID_W; j++) begin
                    if (slot_i == CNT_W'(PRIO_W + j)) bit_level_o = ~id_i[ID_W-1-j];
                end
            end
            ST_IDLE, ST_DONE: bit_level_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/lp_arb_seq.sv
module lp_arb_seq
    import lp_arb_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 4,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_start,
    input  logic             part_i,
    input  logic             level_i,
    input  logic             sense_i,
    output arb_state_e       state_o,
    output logic [CNT_W-1:0] slot_o,
    output logic             lost_o,
    output logic             won_o
);

    localparam int NSLOT = PRIO_W + ID_W;

    arb_state_e       state_q, state_d;
    logic [CNT_W-1:0] slot_q, slot_d;
    logic             lost_q, lost_d;
    logic             won_q, won_d;
    logic             in_arb;
    logic             lose_now;

    assign in_arb   = (state_q == ST_PRIO) || (state_q == ST_TIE);
    assign lose_now = in_arb && level_i && !sense_i;

    // Next-state and output decisions
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        lost_d  = lost_q | lose_now;
        won_d   = won_q;
        if (phase_start) begin
            state_d = ST_PRIO;
            slot_d  = '0;
            lost_d  = 1'b0;
            won_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_PRIO: begin
                    slot_d = slot_q + 1'b1;
                    if (slot_q == CNT_W'(PRIO_W - 1)) state_d = ST_TIE;
                end
                ST_TIE: begin
                    slot_d = slot_q + 1'b1;
                    if (slot_q == CNT_W'(NSLOT - 1)) begin
                        state_d = ST_DONE;
                        won_d   = part_i && !(lost_q || lose_now);
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            lost_q  <= 1'b0;
            won_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            lost_q  <= lost_d;
            won_q   <= won_d;
        end
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;
    assign lost_o  = lost_q;
    assign won_o   = won_q;

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_start |=> (state_q == ST_PRIO && slot_q == '0 && !lost_q && !won_q));

    // R5
    loss_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arb && level_i && !sense_i && !phase_start) |=> lost_q);

    // R6
    won_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(won_q) |-> ($past(state_q) == ST_TIE && state_q == ST_DONE));

endmodule

// File: rtl/lp_arb_node.sv
module lp_arb_node
    import lp_arb_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_start,
    input  logic [PRIO_W-1:0] prio_in,
    input  logic [ID_W-1:0]   arb_id_in,
    input  logic              slot_free,
    input  logic              line1_sense,
    output logic              line1_level,
    output logic              won
);

    localparam int NSLOT = PRIO_W + ID_W;
    localparam int CNT_W = $clog2(NSLOT + 1);

    logic [PRIO_W-1:0] prio_q;
    logic [ID_W-1:0]   id_q;
    logic              part_q;
    arb_state_e        state;
    logic [CNT_W-1:0]  slot;
    logic              lost;
    logic              bit_level;
    logic              active;

    // Latch contender inputs at phase start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            id_q   <= '0;
            part_q <= 1'b0;
        end else if (phase_start) begin
            prio_q <= prio_in;
            id_q   <= arb_id_in;
            part_q <= slot_free;
        end
    end

    lp_arb_seq #(.PRIO_W(PRIO_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_start(phase_start),
        .part_i     (part_q),
        .level_i    (line1_level),
        .sense_i    (line1_sense),
        .state_o    (state),
        .slot_o     (slot),
        .lost_o     (lost),
        .won_o      (won)
    );

    lp_arb_bitsel #(.PRIO_W(PRIO_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_bitsel (
        .state_i    (state),
        .slot_i     (slot),
        .prio_i     (prio_q),
        .id_i       (id_q),
        .bit_level_o(bit_level)
    );

    assign active      = part_q && !lost && (state == ST_PRIO || state == ST_TIE);
    assign line1_level = active ? bit_level : 1'b1;

    // R5
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> line1_level);

    // R4
    no_slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !part_q |-> (line1_level && !won));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (line1_level && !won));

    // R6
    won_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        won |-> (!lost && part_q && state == ST_DONE));

endmodule

// File: tb/lp_arb_node_test.sv
module lp_arb_node_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_start = 1'b0;
    logic [7:0] prio_in = '0;
    logic [3:0] arb_id_in = '0;
    logic       slot_free = 1'b0;
    logic       line1_sense = 1'b1;
    logic       line1_level;
    logic       won;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lp_arb_node uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_start(phase_start),
        .prio_in    (prio_in),
        .arb_id_in  (arb_id_in),
        .slot_free  (slot_free),
        .line1_sense(line1_sense),
        .line1_level(line1_level),
        .won        (won)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic slot_lvl(input logic [7:0] p, input logic [3:0] id, input int k);
        return (k < 8) ? p[7-k] : ~id[11-k];
    endfunction

    // One full phase against a modelled rival; scramble alters inputs after start (R9)
    task automatic run_phase(input logic [7:0] p, input logic [3:0] id, input logic fr,
                             input logic [7:0] rp, input logic [3:0] rid, input logic rfr,
                             input bit scramble, input string tag);
        logic u_lost = 1'b0;
        logic r_lost = 1'b0;
        logic u_exp, r_lvl, exp_won;
        @(negedge clk);
        prio_in = p; arb_id_in = id; slot_free = fr; phase_start = 1'b1; line1_sense = 1'b1;
        @(negedge clk);
        phase_start = 1'b0;
        if (scramble) begin
            prio_in = ~p; arb_id_in = ~id; slot_free = ~fr;
        end
        for (int k = 0; k < 12; k++) begin
            u_exp = (fr && !u_lost) ? slot_lvl(p, id, k) : 1'b1;
            r_lvl = (rfr && !r_lost) ? slot_lvl(rp, rid, k) : 1'b1;
            if (!fr)           check("R4", line1_level, 1'b1, {tag, " released"});
            else if (u_lost)   check("R5", line1_level, 1'b1, {tag, " released after loss"});
            else if (k < 8)    check(scramble ? "R9" : "R2", line1_level, u_exp, {tag, " priority slot"});
            else               check(scramble ? "R9" : "R3", line1_level, u_exp, {tag, " id slot"});
            if (k == 0 || k == 11) check("R6", won, 1'b0, {tag, " won low in phase"});
            line1_sense = line1_level & r_lvl;
            if (u_exp && !line1_sense) u_lost = 1'b1;
            if (r_lvl && !line1_sense) r_lost = 1'b1;
            @(negedge clk);
        end
        line1_sense = 1'b1;
        exp_won = fr && (!rfr || p < rp || (p == rp && id >= rid));
        check(fr ? "R8" : "R4", won, exp_won, {tag, " won"});
        check("R6", won, fr && !u_lost, {tag, " won vs bit model"});
        @(negedge clk);
        check("R6", won, exp_won, {tag, " won held"});
        check("R1", line1_level, 1'b1, {tag, " released after phase"});
    endtask

    task automatic t_reset;
        check("R1", line1_level, 1'b1, "reset level");
        check("R1", won, 1'b0, "reset won");
    endtask

    task automatic t_alone;
        run_phase(8'hA5, 4'h3, 1'b1, 8'h00, 4'h0, 1'b0, 1'b0, "alone");
    endtask

    task automatic t_lower_wins;
        run_phase(8'h20, 4'h1, 1'b1, 8'h40, 4'hF, 1'b1, 1'b0, "lower prio");
        run_phase(8'h41, 4'hF, 1'b1, 8'h40, 4'h0, 1'b1, 1'b0, "higher prio lsb");
    endtask

    task automatic t_tie;
        run_phase(8'h33, 4'h9, 1'b1, 8'h33, 4'h6, 1'b1, 1'b0, "tie high id");
        run_phase(8'h33, 4'h2, 1'b1, 8'h33, 4'h3, 1'b1, 1'b0, "tie low id");
        run_phase(8'h7E, 4'h5, 1'b1, 8'h7E, 4'h5, 1'b1, 1'b0, "tie equal id");
    endtask

    task automatic t_no_slot;
        run_phase(8'h00, 4'hF, 1'b0, 8'hFF, 4'h0, 1'b1, 1'b0, "no slot");
    endtask

    task automatic t_scramble;
        run_phase(8'h10, 4'hC, 1'b1, 8'h11, 4'h0, 1'b1, 1'b1, "inputs changed");
    endtask

    task automatic t_restart;
        @(negedge clk);
        prio_in = 8'hFF; arb_id_in = 4'h0; slot_free = 1'b1; phase_start = 1'b1;
        @(negedge clk);
        phase_start = 1'b0;
        check("R2", line1_level, 1'b1, "restart slot0 level");
        line1_sense = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5", line1_level, 1'b1, "forced loss released");
        line1_sense = 1'b1;
        run_phase(8'h7F, 4'hA, 1'b1, 8'h00, 4'h0, 1'b0, 1'b0, "R7 restart");
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alone();
        t_lower_wins();
        t_tie();
        t_no_slot();
        t_scramble();
        t_restart();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule